// File: doc/BRIEF.md
# Program Busy Status Responder

This block sits on the read path of a flash model and stands in for the array while an internal write cycle runs. A one-cycle start pulse opens a busy window of a fixed number of clock cycles and captures the byte that was loaded last. For as long as the window is open, every read returns a status byte instead of array contents. Bit 7 of that byte is the inverse of bit 7 of the captured byte. Bit 6 is a flip-flop that changes state on each read served during the window. Bits 5 to 0 repeat the captured byte. Once the window closes, reads pass the array byte through unchanged.

Reads are a request/response stream. A request is accepted when `rd_req_valid` and `rd_req_ready` are both high at a rising clock edge. The array byte presented with the request is sampled on that same edge. The response is registered and shows up on the next cycle with `rd_resp_valid` high. It stays there, unchanged, until the consumer raises `rd_resp_ready`. `rd_req_ready` is high only when the response slot is empty or is being drained in the same cycle, so a stalled consumer stops further requests and no read is lost or counted twice. The start pulse and the `busy` flag are plain control and status pins.

Top module: `pbs_poll_responder`

## Requirements
- R1: After reset, `busy` is 0, `rd_resp_valid` is 0, `rd_req_ready` is 1, and the bit-6 flip-flop holds 0.
- R2: A start pulse that arrives while idle raises `busy` on the following cycle. `busy` then stays high for exactly BUSY_CYCLES consecutive cycles and captures `prog_data` on the same edge.
- R3: A start pulse that arrives while `busy` is high is ignored. The captured byte keeps the value from the first start, and the window still closes BUSY_CYCLES cycles after that first start.
- R4: A read accepted while busy returns, on output bit 7, the inverse of bit 7 of the captured byte, whatever array byte is supplied.
- R5: A read accepted while busy returns the current state of the bit-6 flip-flop on output bit 6, then inverts that flip-flop. Successive busy reads therefore alternate. The flip-flop is not cleared when a new window starts.
- R6: A read accepted while busy returns bits 5 to 0 of the captured byte on output bits 5 to 0.
- R7: A read accepted while `busy` is low returns the supplied array byte unchanged on all eight bits, and it does not change the bit-6 flip-flop.
- R8: While `rd_resp_valid` is high and `rd_resp_ready` is low, the response byte stays stable, `rd_req_ready` is low, and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | One-cycle pulse that opens the busy window |
| prog_data | input | 8 | Last loaded byte, captured when the window opens |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Block can accept a read request |
| rd_arr_data | input | 8 | Array byte for the requested address, sampled on acceptance |
| rd_resp_valid | output | 1 | Response byte present |
| rd_resp_ready | input | 1 | Consumer takes the response |
| rd_resp_data | output | 8 | Status byte or array byte |
| busy | output | 1 | Write cycle in progress |

## Verification
The bench counts the busy window cycle by cycle. A counter that is off by one, or that reloads on a second start pulse, changes that count. It sends a second start pulse with a different byte in the middle of a window. A design that recaptures the byte flips the wrong bit 7 and echoes the wrong low bits. It mixes idle reads between busy reads and follows the bit-6 sequence across two windows, which catches a toggle that advances on idle reads or resets at each start. It also stalls the consumer with a second request waiting. A design that overwrites the held response, or accepts the waiting request early, shows a changed byte or an extra toggle step.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int unsigned PBS_DATA_W = 8;
  localparam int unsigned PBS_POLL_BIT = PBS_DATA_W - 1;
  localparam int unsigned PBS_TOG_BIT = PBS_DATA_W - 2;

  typedef logic [PBS_DATA_W-1:0] pbs_byte_t;

  // Status byte served while the write cycle runs
  function automatic pbs_byte_t pbs_status(input pbs_byte_t held, input logic tog);
    pbs_byte_t s;
    s = held;
    s[PBS_POLL_BIT] = ~held[PBS_POLL_BIT];
    s[PBS_TOG_BIT] = tog;
    return s;
  endfunction
endpackage

// File: rtl/pbs_timer.sv
module pbs_timer
  import pbs_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  pbs_byte_t data_i,
  output logic      busy_o,
  output pbs_byte_t held_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      remain_q <= '0;
      held_o   <= '0;
    end else if (!busy_o && start_i) begin
      busy_o   <= 1'b1;
      remain_q <= CNT_LOAD;
      held_o   <= data_i;
    end else if (busy_o) begin
      if (remain_q == '0) busy_o <= 1'b0;
      else remain_q <= remain_q - 1'b1;
    end
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && held_o == $past(data_i))); // R2
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(held_o)); // R3
  AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R2
endmodule

// File: rtl/pbs_toggle.sv
module pbs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_acc_i,
  input  logic busy_i,
  output logic tog_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) tog_o <= 1'b0;
    else if (rd_acc_i && busy_i) tog_o <= ~tog_o;
  end

  AST_TOG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc_i && busy_i) |=> (tog_o != $past(tog_o))); // R5
  AST_TOG_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_acc_i && busy_i) |=> $stable(tog_o)); // R7
endmodule

// File: rtl/pbs_resp.sv
module pbs_resp
  import pbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid_i,
  output logic      req_ready_o,
  input  pbs_byte_t arr_i,
  input  logic      busy_i,
  input  logic      tog_i,
  input  pbs_byte_t held_i,
  output logic      acc_o,
  output logic      resp_valid_o,
  input  logic      resp_ready_i,
  output pbs_byte_t resp_data_o
);
  pbs_byte_t next_byte;

  assign req_ready_o = !resp_valid_o || resp_ready_i;
  assign acc_o = req_valid_i && req_ready_o;
  assign next_byte = busy_i ? pbs_status(held_i, tog_i) : arr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_data_o  <= '0;
    end else if (acc_o) begin
      resp_valid_o <= 1'b1;
      resp_data_o  <= next_byte;
    end else if (resp_ready_i) begin
      resp_valid_o <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && !resp_ready_i) |=> (resp_valid_o && $stable(resp_data_o))); // R8
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && !resp_ready_i) |-> !acc_o); // R8
endmodule

// File: rtl/pbs_poll_responder.sv
module pbs_poll_responder
  import pbs_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_start,
  input  logic [7:0] prog_data,
  input  logic       rd_req_valid,
  output logic       rd_req_ready,
  input  logic [7:0] rd_arr_data,
  output logic       rd_resp_valid,
  input  logic       rd_resp_ready,
  output logic [7:0] rd_resp_data,
  output logic       busy
);
  pbs_byte_t held;
  logic      tog;
  logic      rd_acc;

  pbs_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(prog_start), .data_i(prog_data),
    .busy_o(busy), .held_o(held)
  );

  pbs_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .rd_acc_i(rd_acc), .busy_i(busy), .tog_o(tog)
  );

  pbs_resp u_resp (
    .clk(clk), .rst_n(rst_n), .req_valid_i(rd_req_valid), .req_ready_o(rd_req_ready),
    .arr_i(rd_arr_data), .busy_i(busy), .tog_i(tog), .held_i(held), .acc_o(rd_acc),
    .resp_valid_o(rd_resp_valid), .resp_ready_i(rd_resp_ready), .resp_data_o(rd_resp_data)
  );

  AST_POLL_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && busy) |=> (rd_resp_data[7] == ~$past(held[7]))); // R4
  AST_LOW_BITS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && busy) |=> (rd_resp_data[5:0] == $past(held[5:0]))); // R6
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !busy) |=> (rd_resp_data == $past(rd_arr_data))); // R7
endmodule

// File: tb/sim_pbs_poll_responder.sv
module sim_pbs_poll_responder;
  localparam int unsigned NCYC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_start = 1'b0;
  logic [7:0] prog_data = '0;
  logic       rd_req_valid = 1'b0;
  logic       rd_req_ready;
  logic [7:0] rd_arr_data = '0;
  logic       rd_resp_valid;
  logic       rd_resp_ready = 1'b1;
  logic [7:0] rd_resp_data;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  logic tb_tog = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pbs_poll_responder #(.BUSY_CYCLES(NCYC)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_of(input logic [7:0] held, input logic t);
    return {~held[7], t, held[5:0]};
  endfunction

  task automatic do_read(input logic [7:0] arr, output logic [7:0] d);
    @(negedge clk);
    rd_req_valid = 1'b1;
    rd_arr_data = arr;
    @(negedge clk);
    rd_req_valid = 1'b0;
    check(rd_resp_valid == 1'b1, "R8 resp_valid", int'(rd_resp_valid), 1);
    d = rd_resp_data;
  endtask

  task automatic pulse_start(input logic [7:0] b);
    @(negedge clk);
    prog_start = 1'b1;
    prog_data = b;
    @(negedge clk);
    prog_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(rd_resp_valid == 1'b0, "R1 resp_valid", int'(rd_resp_valid), 0);
    check(rd_req_ready == 1'b1, "R1 req_ready", int'(rd_req_ready), 1);
  endtask

  task automatic t_idle_read();
    logic [7:0] d;
    do_read(8'hA5, d);
    check(d == 8'hA5, "R7 idle data", d, 8'hA5);
    do_read(8'h3C, d);
    check(d == 8'h3C, "R7 idle data", d, 8'h3C);
  endtask

  task automatic t_window_length();
    int cnt;
    logic [7:0] d;
    pulse_start(8'h81);
    cnt = 1;
    while (busy && cnt < 200) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    check(cnt == NCYC, "R2 busy length", cnt, NCYC);
    do_read(8'h5A, d);
    check(d == 8'h5A, "R7 after window", d, 8'h5A);
  endtask

  task automatic t_busy_poll(input logic [7:0] b);
    logic [7:0] d;
    logic [7:0] exp;
    pulse_start(b);
    check(busy == 1'b1, "R2 busy rises", int'(busy), 1);
    for (int i = 0; i < 4; i++) begin
      do_read(8'h00 + 8'(i * 17), d);
      exp = status_of(b, tb_tog);
      check(d[7] == exp[7], "R4 bit7 inverted", d, exp);
      check(d[6] == exp[6], "R5 bit6 toggle", d, exp);
      check(d[5:0] == exp[5:0], "R6 low bits", d, exp);
      tb_tog = ~tb_tog;
    end
    wait_idle();
    do_read(8'hC3, d);
    check(d == 8'hC3, "R7 idle after poll", d, 8'hC3);
  endtask

  task automatic t_restart_ignored();
    int cnt;
    logic [7:0] d;
    logic [7:0] exp;
    pulse_start(8'h2B);
    cnt = 1;
    repeat (3) begin @(negedge clk); cnt++; end
    prog_start = 1'b1;
    prog_data = 8'hD4;
    @(negedge clk);
    prog_start = 1'b0;
    cnt++;
    rd_req_valid = 1'b1;
    rd_arr_data = 8'hFF;
    @(negedge clk);
    rd_req_valid = 1'b0;
    cnt++;
    d = rd_resp_data;
    exp = status_of(8'h2B, tb_tog);
    tb_tog = ~tb_tog;
    check(d == exp, "R3 first byte kept", d, exp);
    while (busy && cnt < 200) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    check(cnt == NCYC, "R3 window not reloaded", cnt, NCYC);
  endtask

  task automatic t_backpressure();
    logic [7:0] d0;
    logic [7:0] exp;
    pulse_start(8'h47);
    rd_resp_ready = 1'b0;
    rd_req_valid = 1'b1;
    rd_arr_data = 8'h11;
    @(negedge clk);
    d0 = rd_resp_data;
    exp = status_of(8'h47, tb_tog);
    tb_tog = ~tb_tog;
    check(d0 == exp, "R8 first stalled byte", d0, exp);
    repeat (3) begin
      @(negedge clk);
      check(rd_resp_valid == 1'b1, "R8 held valid", int'(rd_resp_valid), 1);
      check(rd_resp_data == d0, "R8 held data", rd_resp_data, d0);
      check(rd_req_ready == 1'b0, "R8 ready low", int'(rd_req_ready), 0);
    end
    rd_resp_ready = 1'b1;
    @(negedge clk);
    rd_req_valid = 1'b0;
    exp = status_of(8'h47, tb_tog);
    tb_tog = ~tb_tog;
    check(rd_resp_data == exp, "R8 queued read once", rd_resp_data, exp);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_read();
    t_window_length();
    t_busy_poll(8'h81);
    t_idle_read();
    t_busy_poll(8'h6E);
    t_restart_ignored();
    t_backpressure();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule